// File: doc/BRIEF.md
# Parallel Crosspoint Configuration Port

This block is the slave side of a wide parallel configuration port for a crosspoint switch. A host presents a whole command at once: a 2-bit operation code, two 10-bit port addresses (A and B) and a 4-bit value bus (C). The block latches the command on a falling edge of its configuration clock while the active-low enable is held low. It keeps the configuration state of the switch: one buffer configuration word per port, and a directional connection map that records, for each port A, which ports B it is linked to.

The two write operations finish on the edge that latches them, so a new write can follow on every falling edge. The two read operations use a fixed four-cycle sequence on the same shared pins. The block takes in the command during the first cycles. In the fourth cycle it turns the A, B and C0 pins around to drive the result, and it raises a ready flag for exactly that cycle. The bidirectional pins are modelled as separate input, output and output-enable signals. If the host releases the enable before a read completes, the read is dropped.

Top module: `xpt_cfg_port`

## Requirements
- R1: A command takes effect only on a falling edge of `cfg_clk` at which `cfg_en_n` is low. A command presented with `cfg_en_n` high changes no stored state and starts no read.
- R2: `op_sel` encoding: 00 writes a buffer configuration, 01 writes a crosspoint, 10 reads a buffer configuration, 11 reads a crosspoint.
- R3: A buffer write stores `c_in[3:0]` for port `a_in`. A buffer read of that port drives the stored word on `a_out[3:0]` during its ready cycle. The other `a_out` bits, all of `b_out` and `c0_out` are 0 in that cycle.
- R4: A crosspoint write sets the link from port `a_in` to port `b_in` to `c_in[0]` (1 = connect, 0 = disconnect). The link is directional: A to B is independent of B to A. A crosspoint read drives the link state on `c0_out` and echoes the two addresses on `a_out` and `b_out`.
- R5: Writes can be issued on consecutive falling edges, and each one takes effect.
- R6: For a read latched at falling edge k, `rdy` and `bus_oe` go high at edge k+3 and low at edge k+4. At all other times `bus_oe` is low and `a_out`, `b_out` and `c0_out` are 0.
- R7: Inputs presented at edges k+1 to k+3 of a read are ignored. A write shown during those edges changes nothing.
- R8: With `cfg_en_n` held low, a new command (including another read) is latched at edge k+4, so reads can run back to back.
- R9: Port numbers of `NPORT` or more are out of range. Writes that name one are ignored, and reads that name one return all zeros, including the address echo.
- R10: If `cfg_en_n` is high at any of edges k+1 to k+3, the read is abandoned with no `rdy` pulse, and the next edge with the enable low latches a new command.
- R11: While `rst_n` is low at a falling edge, the block clears every buffer word and every link, goes idle, and drives `rdy`, `bus_oe` and all data outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock; the block acts on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en_n | input | 1 | Active-low command enable |
| op_sel | input | 2 | Operation code |
| a_in | input | 10 | Port address A, input side |
| b_in | input | 10 | Port address B, input side |
| c_in | input | 4 | Value bus C; bit 0 is also the link state |
| a_out | output | 10 | A pins, driven side (read data) |
| b_out | output | 10 | B pins, driven side (read data) |
| c0_out | output | 1 | C0 pin, driven side (link state) |
| bus_oe | output | 1 | Output enable for the A, B and C0 pins |
| rdy | output | 1 | Read data valid |

## Verification
A write is not visible at the pins. Its effect is checked at the ready cycle of a later read, which comes three falling edges after that read was latched. The expected `rdy`, `bus_oe` and data therefore appear exactly at edge k+3 and clear again at edge k+4. The bench keeps a behavioural model that advances on the same falling edges as the design. It compares all outputs on every rising edge, half a period after they change, so every cycle of the sequence is checked. This covers the quiet cycles of each read, the abort path, and the cycles in which ignored commands are shown.

// File: rtl/xpt_cfg_pkg.sv
// Shared definitions for the crosspoint configuration port.
package xpt_cfg_pkg;

    // Operation code carried on op_sel; bit 1 marks a read.
    typedef enum logic [1:0] {
        OP_BUF_WR = 2'b00,
        OP_XPT_WR = 2'b01,
        OP_BUF_RD = 2'b10,
        OP_XPT_RD = 2'b11
    } xpt_op_e;

endpackage

// File: rtl/xpt_cmd_seq.sv
// Command sequencer. It accepts one command per falling edge while idle.
// A write becomes a single-edge strobe. A read runs through three hold
// phases and then a one-cycle ready. Raising the enable during the hold
// phases drops the read.
// Assumes: a synchronous active-low reset sampled on the falling edge.
module xpt_cmd_seq
    import xpt_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_n,
    input  logic [1:0] op,
    output logic       wr_buf,
    output logic       wr_xpt,
    output logic       rd_cap,
    output logic       rd_is_xpt,
    output logic       ld_out,
    output logic       rdy,
    output logic       busy
);

    localparam int PH_W = 2;
    localparam logic [PH_W-1:0] PH_IDLE = '0;
    localparam logic [PH_W-1:0] PH_LAST = '1;

    logic [PH_W-1:0] phase_q;
    logic            op_xpt_q;
    logic            rdy_q;
    logic            accept;

    // Decode the strobes for the current edge from the phase and the inputs.
    always_comb begin
        accept    = (phase_q == PH_IDLE) && !en_n;
        wr_buf    = accept && (xpt_op_e'(op) == OP_BUF_WR);
        wr_xpt    = accept && (xpt_op_e'(op) == OP_XPT_WR);
        rd_cap    = accept && op[1];
        ld_out    = (phase_q == PH_LAST) && !en_n;
        rd_is_xpt = op_xpt_q;
        rdy       = rdy_q;
        busy      = (phase_q != PH_IDLE);
    end

    // Advance the read phase, record the read kind and produce ready.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            op_xpt_q <= 1'b0;
            rdy_q    <= 1'b0;
        end else begin
            rdy_q <= ld_out;
            if (rd_cap) begin
                phase_q  <= PH_IDLE + 1'b1;
                op_xpt_q <= op[0];
            end else if (phase_q != PH_IDLE) begin
                if (en_n || phase_q == PH_LAST)
                    phase_q <= PH_IDLE;
                else
                    phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Ready lasts exactly one cycle.
    assert_rdy_single_R6: assert property (@(negedge clk) disable iff (!rst_n)
        rdy_q |=> !rdy_q);

    // Ready only follows three consecutive edges with the enable held low.
    assert_rdy_held_en_R10: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> (!$past(en_n) && !$past(en_n, 2) && !$past(en_n, 3)));

endmodule

// File: rtl/xpt_cfg_store.sv
// Configuration store: one buffer word per port and a directional link
// matrix (row = port A, column = port B). A write that names an address
// of NPORT or more is dropped. A read of such an address returns zero.
// Assumes: NPORT >= 2 and NPORT <= 2**ADDR_W.
module xpt_cfg_store #(
    parameter int NPORT  = 16,
    parameter int ADDR_W = 10,
    parameter int VAR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_buf,
    input  logic              wr_xpt,
    input  logic [ADDR_W-1:0] wa,
    input  logic [ADDR_W-1:0] wb,
    input  logic [VAR_W-1:0]  wc,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] rb,
    output logic [VAR_W-1:0]  rd_buf,
    output logic              rd_link,
    output logic              ra_ok,
    output logic              rb_ok
);

    localparam int IDX_W = $clog2(NPORT);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NPORT);

    logic [VAR_W-1:0] cfg_q  [NPORT];
    logic [NPORT-1:0] link_q [NPORT];
    logic             wa_ok, wb_ok;
    logic [IDX_W-1:0] wa_idx, wb_idx, ra_idx, rb_idx;

    // Range checks and index extraction for the write and read addresses.
    always_comb begin
        wa_ok  = (wa < LIMIT);
        wb_ok  = (wb < LIMIT);
        ra_ok  = (ra < LIMIT);
        rb_ok  = (rb < LIMIT);
        wa_idx = wa[IDX_W-1:0];
        wb_idx = wb[IDX_W-1:0];
        ra_idx = ra[IDX_W-1:0];
        rb_idx = rb[IDX_W-1:0];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Buffer word and link row of one port.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                cfg_q[p]  <= '0;
                link_q[p] <= '0;
            end else begin
                if (wr_buf && wa_ok && wa_idx == IDX_W'(p))
                    cfg_q[p] <= wc;
                if (wr_xpt && wa_ok && wb_ok && wa_idx == IDX_W'(p))
                    link_q[p][wb_idx] <= wc[0];
            end
        end

        // An out-of-range buffer write leaves every port untouched.
        assert_oor_write_kept_R9: assert property (@(negedge clk) disable iff (!rst_n)
            (wr_buf && !wa_ok && !wr_xpt) |=> $stable(cfg_q[p]));
    end

    // Read multiplexers; out-of-range addresses read as zero.
    always_comb begin
        rd_buf  = ra_ok ? cfg_q[ra_idx] : '0;
        rd_link = (ra_ok && rb_ok) ? link_q[ra_idx][rb_idx] : 1'b0;
    end

endmodule

// File: rtl/xpt_cfg_port.sv
// Top of the parallel crosspoint configuration port. It joins the command
// sequencer and the store, holds the addresses of a read in progress and
// loads the result registers for the ready cycle. The bidirectional pins
// are split into separate in/out ports plus an output enable.
// Assumes: ADDR_W >= VAR_W; everything acts on the falling edge of cfg_clk.
module xpt_cfg_port #(
    parameter int NPORT  = 16,
    parameter int ADDR_W = 10,
    parameter int VAR_W  = 4
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              cfg_en_n,
    input  logic [1:0]        op_sel,
    input  logic [ADDR_W-1:0] a_in,
    input  logic [ADDR_W-1:0] b_in,
    input  logic [VAR_W-1:0]  c_in,
    output logic [ADDR_W-1:0] a_out,
    output logic [ADDR_W-1:0] b_out,
    output logic              c0_out,
    output logic              bus_oe,
    output logic              rdy
);

    logic              wr_buf, wr_xpt, rd_cap, rd_is_xpt, ld_out, busy;
    logic [ADDR_W-1:0] ca_q, cb_q;
    logic [VAR_W-1:0]  rd_buf;
    logic              rd_link, ra_ok, rb_ok;
    logic [ADDR_W-1:0] a_out_q, b_out_q;
    logic              c0_out_q;

    xpt_cmd_seq u_seq (
        .clk       (cfg_clk),
        .rst_n     (rst_n),
        .en_n      (cfg_en_n),
        .op        (op_sel),
        .wr_buf    (wr_buf),
        .wr_xpt    (wr_xpt),
        .rd_cap    (rd_cap),
        .rd_is_xpt (rd_is_xpt),
        .ld_out    (ld_out),
        .rdy       (rdy),
        .busy      (busy)
    );

    xpt_cfg_store #(
        .NPORT  (NPORT),
        .ADDR_W (ADDR_W),
        .VAR_W  (VAR_W)
    ) u_store (
        .clk     (cfg_clk),
        .rst_n   (rst_n),
        .wr_buf  (wr_buf),
        .wr_xpt  (wr_xpt),
        .wa      (a_in),
        .wb      (b_in),
        .wc      (c_in),
        .ra      (ca_q),
        .rb      (cb_q),
        .rd_buf  (rd_buf),
        .rd_link (rd_link),
        .ra_ok   (ra_ok),
        .rb_ok   (rb_ok)
    );

    // Hold the read addresses from the capture edge to the end of the read.
    always_ff @(negedge cfg_clk) begin
        if (!rst_n) begin
            ca_q <= '0;
            cb_q <= '0;
        end else if (rd_cap) begin
            ca_q <= a_in;
            cb_q <= b_in;
        end
    end

    // Load the result for the ready cycle and clear it otherwise.
    always_ff @(negedge cfg_clk) begin
        if (!rst_n || !ld_out) begin
            a_out_q  <= '0;
            b_out_q  <= '0;
            c0_out_q <= 1'b0;
        end else if (rd_is_xpt) begin
            a_out_q  <= (ra_ok && rb_ok) ? ca_q : '0;
            b_out_q  <= (ra_ok && rb_ok) ? cb_q : '0;
            c0_out_q <= rd_link;
        end else begin
            a_out_q  <= ADDR_W'(rd_buf);
            b_out_q  <= '0;
            c0_out_q <= 1'b0;
        end
    end

    // Drive the pin outputs; the pins turn around only while ready is high.
    always_comb begin
        a_out  = a_out_q;
        b_out  = b_out_q;
        c0_out = c0_out_q;
        bus_oe = rdy;
    end

    // Outside the ready cycle the data outputs stay at zero.
    assert_quiet_bus_R6: assert property (@(negedge cfg_clk) disable iff (!rst_n)
        !rdy |-> (a_out == '0 && b_out == '0 && !c0_out));

    // No store write is issued while a read is in progress.
    assert_no_write_busy_R7: assert property (@(negedge cfg_clk) disable iff (!rst_n)
        busy |-> !(wr_buf || wr_xpt));

endmodule

// File: tb/test_xpt_cfg_port.sv
// Self-checking bench. A behavioural model advances on each falling edge.
// All outputs are compared with the model on every rising edge.
module test_xpt_cfg_port;

    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic [1:0] op_sel = 2'b00;
    logic [9:0] a_in = '0, b_in = '0;
    logic [3:0] c_in = '0;
    logic [9:0] a_out, b_out;
    logic       c0_out, bus_oe, rdy;

    always #4 clk = ~clk;

    xpt_cfg_port i_xpt_cfg_port (
        .cfg_clk  (cfg_clk_w),
        .rst_n    (rst_n),
        .cfg_en_n (en_n),
        .op_sel   (op_sel),
        .a_in     (a_in),
        .b_in     (b_in),
        .c_in     (c_in),
        .a_out    (a_out),
        .b_out    (b_out),
        .c0_out   (c0_out),
        .bus_oe   (bus_oe),
        .rdy      (rdy)
    );

    wire cfg_clk_w = clk;

    int    n_chk = 0, n_fail = 0;
    string tag = "R11";
    bit    chk_on = 0, done = 0;

    // Behavioural model state.
    int         m_cfg [NP];
    bit         m_link [NP][NP];
    int         m_left = 0;
    int         m_op = 0;
    int         m_a = 0, m_b = 0;
    logic       e_rdy = 0, e_c0 = 0;
    logic [9:0] e_a = '0, e_b = '0;

    // Model: acts on the same falling edge as the design.
    always @(negedge clk) begin
        e_rdy = 0; e_a = '0; e_b = '0; e_c0 = 0;
        if (!rst_n) begin
            foreach (m_cfg[i]) m_cfg[i] = 0;
            foreach (m_link[i, j]) m_link[i][j] = 0;
            m_left = 0;
        end else if (m_left == 0) begin
            if (!en_n) begin
                case (op_sel)
                    2'b00: if (a_in < NP) m_cfg[a_in] = int'(c_in);
                    2'b01: if (a_in < NP && b_in < NP) m_link[a_in][b_in] = c_in[0];
                    default: begin
                        m_left = 3; m_op = int'(op_sel);
                        m_a = int'(a_in); m_b = int'(b_in);
                    end
                endcase
            end
        end else if (en_n) begin
            m_left = 0;
        end else begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                e_rdy = 1;
                if (m_op == 2 && m_a < NP) e_a = 10'(m_cfg[m_a]);
                if (m_op == 3 && m_a < NP && m_b < NP) begin
                    e_a = 10'(m_a); e_b = 10'(m_b); e_c0 = m_link[m_a][m_b];
                end
            end
        end
    end

    // Compare all outputs half a period after they change.
    always @(posedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (rdy !== e_rdy || bus_oe !== e_rdy || a_out !== e_a ||
                b_out !== e_b || c0_out !== e_c0) begin
                n_fail++;
                $display("FAIL %s: rdy/oe/a/b/c0 got %b/%b/%h/%h/%b expected %b/%b/%h/%h/%b",
                         tag, rdy, bus_oe, a_out, b_out, c0_out,
                         e_rdy, e_rdy, e_a, e_b, e_c0);
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [9:0] a, input logic [9:0] b,
                         input logic [3:0] c, input string t);
        @(posedge clk);
        tag = t; en_n = 1'b0; op_sel = op; a_in = a; b_in = b; c_in = c;
    endtask

    // Read: latch edge plus three held edges; optionally show a write meanwhile.
    task automatic rd(input logic [1:0] op, input logic [9:0] a, input logic [9:0] b,
                      input bit noise, input string t);
        issue(op, a, b, 4'h0, t);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            if (noise) begin op_sel = 2'b00; a_in = 10'd3; c_in = 4'h0; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            en_n = 1'b1;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk_on = 1;
        idle(2);
        @(posedge clk); rst_n = 1'b1;
        idle(2);
        // R3 and R5: back-to-back buffer writes, then reads.
        issue(2'b00, 10'd3, 10'd0, 4'hA, "R5");
        issue(2'b00, 10'd15, 10'd0, 4'h5, "R5");
        idle(1);
        // R1: command with the enable high is ignored.
        @(posedge clk); tag = "R1"; op_sel = 2'b00; a_in = 10'd3; c_in = 4'h1;
        idle(1);
        rd(2'b10, 10'd3, 10'd0, 0, "R3");
        // R8: back-to-back read with the enable kept low.
        rd(2'b10, 10'd15, 10'd0, 0, "R8");
        idle(2);
        // R4 and R2: directional crosspoint links.
        issue(2'b01, 10'd2, 10'd7, 4'h1, "R2");
        rd(2'b11, 10'd2, 10'd7, 0, "R4");
        rd(2'b11, 10'd7, 10'd2, 0, "R4");
        issue(2'b01, 10'd2, 10'd7, 4'h0, "R4");
        rd(2'b11, 10'd2, 10'd7, 0, "R4");
        issue(2'b01, 10'd9, 10'd9, 4'hF, "R2");
        rd(2'b11, 10'd9, 10'd9, 0, "R2");
        idle(1);
        // R9: out-of-range addresses.
        issue(2'b00, 10'd20, 10'd0, 4'hF, "R9");
        issue(2'b01, 10'd1, 10'd500, 4'h1, "R9");
        rd(2'b10, 10'd20, 10'd0, 0, "R9");
        rd(2'b10, 10'd4, 10'd0, 0, "R9");
        rd(2'b11, 10'd1, 10'd500, 0, "R9");
        rd(2'b11, 10'd1023, 10'd1, 0, "R9");
        idle(1);
        // R7: a write shown during the hold edges is ignored.
        rd(2'b10, 10'd3, 10'd0, 1, "R7");
        rd(2'b10, 10'd3, 10'd0, 0, "R7");
        idle(1);
        // R10: the enable rises in the middle of a read.
        issue(2'b10, 10'd3, 10'd0, 4'h0, "R10");
        @(posedge clk);
        idle(3);
        issue(2'b00, 10'd6, 10'd0, 4'hC, "R10");
        rd(2'b10, 10'd6, 10'd0, 0, "R10");
        issue(2'b11, 10'd9, 10'd9, 4'h0, "R10");
        @(posedge clk); @(posedge clk);
        idle(3);
        // R6: plain read followed by quiet cycles.
        rd(2'b10, 10'd15, 10'd0, 0, "R6");
        idle(3);
        // R11: reset clears the store.
        @(posedge clk); tag = "R11"; rst_n = 1'b0;
        idle(2);
        @(posedge clk); rst_n = 1'b1;
        rd(2'b10, 10'd3, 10'd0, 0, "R11");
        rd(2'b11, 10'd9, 10'd9, 0, "R11");
        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule